// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM stream, carried on a bit clock, a word-select line and a single data line, into parallel left and right samples. It runs entirely in the bit-clock domain: every input is sampled on the rising edge of the bit clock. Each sample arrives MSB first in two's complement.

A 3-bit format code picks one of eight framings. Four of them are LSB-justified, where the word ends on the last bit clock of the half-frame. Two are MSB-justified, where the word starts on the first bit clock. Two are I2S-style, where the MSB trails the word-select edge by one bit clock.

The format code is written into an internal register through a one-cycle write strobe. Both output words are left-aligned in 32 bits, so the sign is always at bit 31. A one-cycle frame-valid pulse marks the cycle in which a fresh left/right pair appears. Crossing the samples into a system clock domain is left to the logic that receives them.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_o` and `right_o` are zero and `frame_valid_o` is low. The format register holds code 2 (24-bit MSB-justified) until it is written.
- R2: In the non-I2S codes (0, 1, 2, 4, 5, 6), the left half-frame is sent while `ws_i` is high and the right half-frame while it is low. The first rising edge that samples the new `ws_i` level also samples the first bit of the new half-frame.
- R3: In codes 3 (24-bit) and 7 (32-bit), the left half-frame is sent while `ws_i` is low and the right half-frame while it is high. The MSB is sampled one rising edge after the first edge that sees the new `ws_i` level.
- R4: Codes 0, 1, 4 and 5 are LSB-justified with word widths 16, 20, 24 and 32. The word is made of the last N bits of the half-frame, and any bits before them are ignored.
- R5: Codes 2 and 6 are MSB-justified with widths 24 and 32 (I2S codes take the first N bits of their shifted slot in the same way). The word is made of the first N bits, and later bits are ignored. Sending 16- or 20-bit data in code 2 with the unused low bits at zero yields those words unchanged.
- R6: Each output word holds its N received bits in bits 31 down to 32-N, with the remaining low bits at zero.
- R7: `frame_valid_o` is high for exactly one cycle. It follows the rising edge at which the half-frame after the right half-frame begins. In that same cycle both output words take the new pair, and they hold their values in every other cycle.
- R8: A half-frame may last from N up to 64 bit clocks. A 64-clock half-frame in code 5 and a 16-clock half-frame in code 0 are both received correctly.
- R9: Pulsing `fmt_wr_i` for one cycle loads `fmt_i` into the format register. The new code governs every later edge.
- R10: A right half-frame that completes before any full left half-frame has been received after reset does not raise `frame_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_i | input | 1 | Word-select (channel) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_wr_i | input | 1 | One-cycle strobe that loads `fmt_i` |
| fmt_i | input | 3 | Framing code 0..7 |
| left_o | output | 32 | Left sample, left-aligned two's complement |
| right_o | output | 32 | Right sample, left-aligned two's complement |
| frame_valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The embedded assertions watch, on every cycle, that the valid pulse never lasts two cycles, that it only follows a detected half-frame boundary, and that the outputs never move outside that pulse. They also check that a presented right word has zeros below its active width and that the slot bit counter never passes its ceiling. Whether the right bits are picked for each of the eight codes, that the I2S one-clock offset is honoured, that padding bits are ignored, and that the pulse lands in the exact predicted cycle can only be shown by the bench. The bench does this by sending framed words with known values and comparing what comes back.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    localparam int WORD_W = 32;
    localparam int WID_W  = $clog2(WORD_W) + 1;
    localparam int FMT_W  = 3;
    localparam logic [FMT_W-1:0] FMT_DEFAULT = 3'd2;

    typedef enum logic [1:0] {
        JUST_MSB = 2'd0,
        JUST_LSB = 2'd1,
        JUST_I2S = 2'd2
    } just_e;

    typedef struct packed {
        just_e              kind;
        logic [WID_W-1:0]   width;
    } fmt_info_t;

    // Framing code to justification kind and word width.
    function automatic fmt_info_t decode_fmt(input logic [FMT_W-1:0] code);
        fmt_info_t r;
        unique case (code)
            3'd0:    begin r.kind = JUST_LSB; r.width = WID_W'(16); end
            3'd1:    begin r.kind = JUST_LSB; r.width = WID_W'(20); end
            3'd2:    begin r.kind = JUST_MSB; r.width = WID_W'(24); end
            3'd3:    begin r.kind = JUST_I2S; r.width = WID_W'(24); end
            3'd4:    begin r.kind = JUST_LSB; r.width = WID_W'(24); end
            3'd5:    begin r.kind = JUST_LSB; r.width = WID_W'(32); end
            3'd6:    begin r.kind = JUST_MSB; r.width = WID_W'(32); end
            default: begin r.kind = JUST_I2S; r.width = WID_W'(32); end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sarx_align.sv
// Word-select alignment: finds half-frame boundaries, delaying by one bit
// clock in the I2S codes so that the boundary lands on the MSB.
module sarx_align
(
    input  logic clk,
    input  logic rst_n,
    input  logic ws_i,
    input  logic i2s_i,
    output logic boundary_o,
    output logic left_o
);
    typedef struct packed {
        logic ws1;
        logic ws2;
    } align_t;

    align_t st_d, st_q;
    logic   cur_ws;
    logic   prev_ws;

    always_comb begin
        st_d.ws1   = ws_i;
        st_d.ws2   = st_q.ws1;
        cur_ws     = i2s_i ? st_q.ws1 : ws_i;
        prev_ws    = i2s_i ? st_q.ws2 : st_q.ws1;
        boundary_o = (cur_ws != prev_ws);
        left_o     = i2s_i ? ~cur_ws : cur_ws;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sarx_slot.sv
// Per-half-frame shifters: one keeps the most recent bits (LSB-justified),
// the other keeps only the first N bits (MSB-justified and I2S).
module sarx_slot
    import sarx_pkg::*;
#(
    parameter int MAX_SLOT = 64,
    parameter int CNT_W    = $clog2(MAX_SLOT + 1)
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              boundary_i,
    input  logic [WID_W-1:0]  width_i,
    output logic [WORD_W-1:0] lsb_o,
    output logic [WORD_W-1:0] msb_o
);
    typedef struct packed {
        logic [WORD_W-1:0] lsb;
        logic [WORD_W-1:0] msb;
        logic [CNT_W-1:0]  cnt;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary_i) begin
            st_d.lsb = WORD_W'(sdata_i);
            st_d.msb = WORD_W'(sdata_i);
            st_d.cnt = CNT_W'(1);
        end else begin
            st_d.lsb = {st_q.lsb[WORD_W-2:0], sdata_i};
            if (st_q.cnt < CNT_W'(width_i)) begin
                st_d.msb = {st_q.msb[WORD_W-2:0], sdata_i};
            end
            if (st_q.cnt != CNT_W'(MAX_SLOT)) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsb_o = st_q.lsb;
    assign msb_o = st_q.msb;

    // Slot bit counter saturates at the longest half-frame.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_SLOT));
endmodule

// File: rtl/sarx_pick.sv
// Selects the captured bits for the active code and left-aligns them.
module sarx_pick
    import sarx_pkg::*;
(
    input  fmt_info_t         info_i,
    input  logic [WORD_W-1:0] lsb_i,
    input  logic [WORD_W-1:0] msb_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WID_W-1:0]  shamt;
    logic [WORD_W-1:0] src;

    always_comb begin
        shamt  = WID_W'(WORD_W) - info_i.width;
        src    = (info_i.kind == JUST_LSB) ? lsb_i : msb_i;
        word_o = src << shamt;
    end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int MAX_SLOT = 64
)
(
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              ws_i,
    input  logic              sdata_i,
    input  logic              fmt_wr_i,
    input  logic [FMT_W-1:0]  fmt_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              frame_valid_o
);
    localparam int CNT_W = $clog2(MAX_SLOT + 1);

    typedef struct packed {
        logic [FMT_W-1:0]  fmt;
        logic              started;
        logic              chan_left;
        logic              have_left;
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] lout;
        logic [WORD_W-1:0] rout;
        logic              valid;
    } top_t;

    top_t              st_d, st_q;
    fmt_info_t         info;
    logic              is_i2s;
    logic              bnd;
    logic              bnd_left;
    logic [WORD_W-1:0] lsb_w;
    logic [WORD_W-1:0] msb_w;
    logic [WORD_W-1:0] word;

    assign info   = decode_fmt(st_q.fmt);
    assign is_i2s = (info.kind == JUST_I2S);

    sarx_align u_align (
        .clk        (clk_bit),
        .rst_n      (rst_n),
        .ws_i       (ws_i),
        .i2s_i      (is_i2s),
        .boundary_o (bnd),
        .left_o     (bnd_left)
    );

    sarx_slot #(.MAX_SLOT(MAX_SLOT), .CNT_W(CNT_W)) u_slot (
        .clk        (clk_bit),
        .rst_n      (rst_n),
        .sdata_i    (sdata_i),
        .boundary_i (bnd),
        .width_i    (info.width),
        .lsb_o      (lsb_w),
        .msb_o      (msb_w)
    );

    sarx_pick u_pick (
        .info_i (info),
        .lsb_i  (lsb_w),
        .msb_i  (msb_w),
        .word_o (word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (fmt_wr_i) begin
            st_d.fmt = fmt_i;
        end
        if (bnd) begin
            if (st_q.started) begin
                if (st_q.chan_left) begin
                    st_d.hold      = word;
                    st_d.have_left = 1'b1;
                end else if (st_q.have_left) begin
                    st_d.lout      = st_q.hold;
                    st_d.rout      = word;
                    st_d.valid     = 1'b1;
                    st_d.have_left = 1'b0;
                end
            end
            st_d.started   = 1'b1;
            st_d.chan_left = bnd_left;
        end
    end

    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fmt <= FMT_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o        = st_q.lout;
    assign right_o       = st_q.rout;
    assign frame_valid_o = st_q.valid;

    assert_single_pulse_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    assert_hold_outputs_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !frame_valid_o |-> ($stable(left_o) && $stable(right_o)));

    assert_valid_after_edge_R7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        frame_valid_o |-> $past(bnd));

    assert_low_bits_zero_R6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        frame_valid_o |-> ((right_o << $past(info.width)) == '0));
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        fmt_wr_i = 1'b0;
    logic [2:0]  fmt_i = 3'd0;
    logic [31:0] left_o;
    logic [31:0] right_o;
    logic        frame_valid_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_start = 0;
    logic prev_bit = 1'b0;

    logic [31:0] cap_l [4];
    logic [31:0] cap_r [4];
    int          cap_c [4];
    int          cap_n = 0;

    serial_audio_rx u0 (
        .clk_bit       (clk),
        .rst_n         (rst_n),
        .ws_i          (ws_i),
        .sdata_i       (sdata_i),
        .fmt_wr_i      (fmt_wr_i),
        .fmt_i         (fmt_i),
        .left_o        (left_o),
        .right_o       (right_o),
        .frame_valid_o (frame_valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && frame_valid_o) begin
            if (cap_n < 4) begin
                cap_l[cap_n] = left_o;
                cap_r[cap_n] = right_o;
                cap_c[cap_n] = cyc;
            end
            cap_n = cap_n + 1;
        end
    end

    function automatic int width_of(int f);
        case (f)
            0: return 16;
            1: return 20;
            2, 3, 4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic bit is_lsb(int f);
        return (f == 0) || (f == 1) || (f == 4) || (f == 5);
    endfunction

    function automatic bit is_i2s(int f);
        return (f == 3) || (f == 7);
    endfunction

    // Logical bit i of a half-frame of length b; padding is driven as ones.
    function automatic logic lbit(int f, int b, logic [31:0] w, int i);
        int n;
        n = width_of(f);
        if (is_lsb(f)) return (i >= b - n) ? w[b-1-i] : 1'b1;
        return (i < n) ? w[n-1-i] : 1'b1;
    endfunction

    function automatic logic [31:0] expw(int f, logic [31:0] w);
        int n;
        logic [31:0] m;
        n = width_of(f);
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        return (w & m) << (32 - n);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic wsv, logic d);
        @(negedge clk);
        ws_i = wsv;
        sdata_i = d;
    endtask

    task automatic send_half(int f, int b, bit left, logic [31:0] w);
        for (int i = 0; i < b; i++) begin
            logic lb;
            logic wsv;
            lb  = lbit(f, b, w, i);
            wsv = is_i2s(f) ? ~left : left;
            drive(wsv, is_i2s(f) ? prev_bit : lb);
            prev_bit = lb;
            if (i == 0) t_start = cyc;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ws_i = 1'b0;
        sdata_i = 1'b0;
        fmt_wr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0;
        prev_bit = 1'b0;
    endtask

    task automatic run_case(string req, int f, bit load, int b,
                            logic [31:0] la, logic [31:0] ra,
                            logic [31:0] lb, logic [31:0] rb);
        int tf2;
        logic left_lvl;
        do_reset();
        if (load) begin
            @(negedge clk);
            fmt_i = 3'(f);
            fmt_wr_i = 1'b1;
            @(negedge clk);
            fmt_wr_i = 1'b0;
        end
        left_lvl = is_i2s(f) ? 1'b0 : 1'b1;
        repeat (4) drive(~left_lvl, 1'b0);
        prev_bit = 1'b0;
        send_half(f, b, 1'b1, la);
        send_half(f, b, 1'b0, ra);
        send_half(f, b, 1'b1, lb);
        tf2 = t_start;
        send_half(f, b, 1'b0, rb);
        drive(left_lvl, is_i2s(f) ? prev_bit : 1'b0);
        repeat (3) drive(left_lvl, 1'b0);
        repeat (3) @(negedge clk);
        check({req, " R7 R10"}, "pulse count", 32'(cap_n), 32'd2);
        check(req, "left 0", cap_l[0], expw(f, la));
        check(req, "right 0", cap_r[0], expw(f, ra));
        check(req, "left 1", cap_l[1], expw(f, lb));
        check(req, "right 1", cap_r[1], expw(f, rb));
        check("R7", "pulse cycle", 32'(cap_c[0]), 32'(tf2 + 1 + (is_i2s(f) ? 1 : 0)));
        check("R7", "held left", left_o, expw(f, lb));
    endtask

    task automatic test_reset_state();
        do_reset();
        @(negedge clk);
        check("R1", "left after reset", left_o, 32'h0);
        check("R1", "right after reset", right_o, 32'h0);
        check("R1", "valid after reset", 32'(frame_valid_o), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset_state();
        // R1 default code 2 without a write; R2 framing, R5 and R6 alignment
        run_case("R1 R2 R5 R6", 2, 1'b0, 32, 32'h0012_3456, 32'h00FE_DCBA, 32'h0080_0001, 32'h007F_FFFF);
        // R5 16-bit data zero-padded inside code 2
        run_case("R5 R6", 2, 1'b1, 32, 32'h00AB_CD00, 32'h0080_0000, 32'h0012_3400, 32'h00FF_FF00);
        // R5 code 6 with ignored trailing ones; R9 format write
        run_case("R5 R9", 6, 1'b1, 40, 32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF, 32'h0123_4567);
        // R3 I2S, 24-bit and 32-bit
        run_case("R3 R9", 3, 1'b1, 32, 32'h00C0_FFEE, 32'h0000_0001, 32'h0080_0000, 32'h007F_FFFF);
        run_case("R3 R9", 7, 1'b1, 32, 32'hA5A5_5A5A, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF);
        // R4 LSB-justified codes; R8 short and long half-frames
        run_case("R4 R8", 0, 1'b1, 16, 32'h0000_8001, 32'h0000_7FFE, 32'h0000_1234, 32'h0000_FFFF);
        run_case("R4 R9", 1, 1'b1, 32, 32'h0008_0000, 32'h0007_FFFF, 32'h000A_BCDE, 32'h0000_0001);
        run_case("R4 R6", 4, 1'b1, 48, 32'h0080_0001, 32'h0012_3456, 32'h00FF_FFFF, 32'h0000_0000);
        run_case("R4 R8", 5, 1'b1, 64, 32'h8765_4321, 32'h0000_0001, 32'hFFFF_FFFE, 32'h7FFF_FFFF);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule